// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Unit

This block is a small counter engine with one compare channel. An 8-bit counter moves one step on each enabled tick. A control field picks where the ticks come from. The choices are none, a prescaled system tick, or an external slow tick that has already been brought into the system clock domain. The count runs in one of four modes. These are free-running, clear-on-match, fast PWM and phase-correct PWM. In phase-correct PWM the counter climbs to its maximum and then walks back down to zero.

A compare value is checked against the count on every step. In the two PWM modes, a written compare value waits in a holding register and becomes active only at the top of the count. In the other modes it takes effect at once. A match on a step sets a sticky match flag and drives a single waveform pin. The rule for the pin depends on the mode. A sticky overflow flag marks the point where the count turns over. Software uses a four-word register bus to:
- set the mode and the tick source;
- read or load the count;
- write the compare value;
- clear the flags.

Top module: `tmr8_unit`

## Requirements
- R1: After reset the control word, count, compare value, flags, `wave_out`, `match_irq` and `ovf_irq` are all zero. Address 0 is the control word, address 1 the count, address 2 the compare value and address 3 the flag word.
- R2: When control bit 2 (run) is 0, no tick input changes the count.
- R3: Control bit 3 selects the tick source. At 0 only `presc_tick` advances the count; at 1 only `ext_tick` does.
- R4: The mode is in control bits [1:0]. In mode 0 (free-running) the count steps up by one per tick and rolls from 0xFF to 0x00. That roll sets the overflow flag, which is bit 1 of the flag word and drives `ovf_irq`.
- R5: On a tick where the count equals the active compare value, the match flag is set. It is bit 0 of the flag word and drives `match_irq`. Each flag stays set until a write to address 3 carries a 1 in that flag's bit position, and bits written as 0 leave their flag unchanged.
- R6: In mode 2 (clear-on-match), a tick on which the count equals the compare value returns the count to 0x00 and does not set the overflow flag.
- R7: In modes 1 and 3, a compare write only updates the holding register, which is what address 2 reads back. The active value loads from it on the tick at count 0xFF (for mode 1, while rising). In modes 0 and 2, a compare write is active at once.
- R8: In mode 3 (fast PWM), the roll from 0xFF to 0x00 sets `wave_out` to 1, and a compare match clears it. When both happen on the same tick, the roll wins.
- R9: A bus write to the count suppresses any compare match on the next tick.
- R10: In mode 1 (phase-correct), the count rises to 0xFF and then falls to 0x00, and the turn at 0xFF moves to 0xFE. The step that lands on 0x00 while falling sets the overflow flag. A match while rising clears `wave_out`, and a match while falling sets it.
- R11: In modes 0 and 2, each compare match inverts `wave_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_tick | input | 1 | One-cycle tick from the system prescaler |
| ext_tick | input | 1 | One-cycle tick from the synchronised external source |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the strobe |
| bus_rvalid | output | 1 | Marks the cycle in which `bus_rdata` holds read data |
| wave_out | output | 1 | Waveform pin |
| match_irq | output | 1 | Sticky compare-match flag |
| ovf_irq | output | 1 | Sticky overflow flag |

## Verification
The bench builds the unit with its default 8-bit width, so every roll point and every turning point of the count can be reached with a few hundred ticks. The scenarios are driven from specific starting counts:
- a count written to 0xFE or 0xFD reaches the 0xFF top;
- a count written on top of a pending match exercises the suppression after a count write;
- a long descent in phase-correct mode reaches the bottom overflow.

Because the width is kept at 8, the full down-and-up sweep of phase-correct mode and the holding-register load at the top stay within a short run.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PHASE = 2'd1,
    MODE_CLR   = 2'd2,
    MODE_FAST  = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CMP  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd3;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] ocr_act,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         blocked,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic step;
  assign step = tick && !wr_en;

  always_comb begin
    ovf_evt = 1'b0;
    if (step) begin
      if (mode == MODE_PHASE) ovf_evt = dir_down && (cnt == ONE);
      else                    ovf_evt = (cnt == MAXV);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= ZERO;
      dir_down <= 1'b0;
      blocked  <= 1'b0;
    end else begin
      if (mode != MODE_PHASE) dir_down <= 1'b0;
      if (wr_en) begin
        cnt     <= wr_val;
        blocked <= 1'b1;
      end else if (tick) begin
        blocked <= 1'b0;
        case (mode)
          MODE_CLR: cnt <= (cnt == ocr_act) ? ZERO : cnt + ONE;
          MODE_PHASE: begin
            if (!dir_down) begin
              if (cnt == MAXV) begin
                dir_down <= 1'b1;
                cnt      <= MAXV - ONE;
              end else begin
                cnt <= cnt + ONE;
              end
            end else begin
              if (cnt == ZERO) begin
                dir_down <= 1'b0;
                cnt      <= ONE;
              end else begin
                cnt <= cnt - ONE;
              end
            end
          end
          default: cnt <= cnt + ONE;
        endcase
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(cnt));

  assert_ctc_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_CLR && cnt == ocr_act) |=> (cnt == ZERO));

  assert_phase_turn_R10: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_PHASE && !dir_down && cnt == MAXV) |=> (cnt == MAXV - ONE && dir_down));
endmodule

// File: rtl/tmr8_compare.sv
module tmr8_compare
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  tmr_mode_e    mode,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic         buf_wr,
  input  logic [W-1:0] buf_val,
  input  logic [W-1:0] cnt,
  input  logic         dir_down,
  input  logic         blocked,
  output logic [W-1:0] ocr_buf,
  output logic [W-1:0] ocr_act,
  output logic         match_evt,
  output logic         wave
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic pwm_mode, step, at_max, load_top, roll;

  assign pwm_mode  = (mode == MODE_FAST) || (mode == MODE_PHASE);
  assign step      = tick && !cnt_wr;
  assign at_max    = (cnt == MAXV);
  assign match_evt = step && !blocked && (cnt == ocr_act);
  assign load_top  = step && at_max &&
                     ((mode == MODE_FAST) || (mode == MODE_PHASE && !dir_down));
  assign roll      = step && at_max && (mode == MODE_FAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (buf_wr) ocr_buf <= buf_val;
      if (!pwm_mode) begin
        if (buf_wr) ocr_act <= buf_val;
      end else if (load_top) begin
        ocr_act <= ocr_buf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
    end else begin
      case (mode)
        MODE_FAST: begin
          if (roll)           wave <= 1'b1;
          else if (match_evt) wave <= 1'b0;
        end
        MODE_PHASE: if (match_evt) wave <= dir_down;
        default:    if (match_evt) wave <= !wave;
      endcase
    end
  end

  assert_hold_active_R7: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !load_top) |=> $stable(ocr_act));

  assert_write_block_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_wr) && !cnt_wr) |-> !match_evt);

  assert_fast_roll_R8: assert property (@(posedge clk) disable iff (rst)
    roll |=> wave);
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                presc_tick,
  input  logic                ext_tick,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [W-1:0]        bus_wdata,
  output logic [W-1:0]        bus_rdata,
  output logic                bus_rvalid,
  output logic                wave_out,
  output logic                match_irq,
  output logic                ovf_irq
);
  localparam int CTRL_BITS = 4;

  tmr_mode_e     mode_q;
  logic          run_q, ext_q;
  logic          tick;
  logic          cnt_wr, cmp_wr, flag_wr;
  logic [W-1:0]  cnt, ocr_buf, ocr_act;
  logic          dir_down, blocked, ovf_evt, match_evt, wave;

  assign tick    = run_q && (ext_q ? ext_tick : presc_tick);
  assign cnt_wr  = bus_we && (bus_addr == ADR_CNT);
  assign cmp_wr  = bus_we && (bus_addr == ADR_CMP);
  assign flag_wr = bus_we && (bus_addr == ADR_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FREE;
      run_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else if (bus_we && bus_addr == ADR_CTRL) begin
      mode_q <= tmr_mode_e'(bus_wdata[1:0]);
      run_q  <= bus_wdata[2];
      ext_q  <= bus_wdata[3];
    end
  end

  tmr8_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode     (mode_q),
    .wr_en    (cnt_wr),
    .wr_val   (bus_wdata),
    .ocr_act  (ocr_act),
    .cnt      (cnt),
    .dir_down (dir_down),
    .blocked  (blocked),
    .ovf_evt  (ovf_evt)
  );

  tmr8_compare #(.W(W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .buf_wr    (cmp_wr),
    .buf_val   (bus_wdata),
    .cnt       (cnt),
    .dir_down  (dir_down),
    .blocked   (blocked),
    .ocr_buf   (ocr_buf),
    .ocr_act   (ocr_act),
    .match_evt (match_evt),
    .wave      (wave)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_irq <= 1'b0;
      ovf_irq   <= 1'b0;
    end else begin
      if (match_evt)                    match_irq <= 1'b1;
      else if (flag_wr && bus_wdata[0]) match_irq <= 1'b0;
      if (ovf_evt)                      ovf_irq   <= 1'b1;
      else if (flag_wr && bus_wdata[1]) ovf_irq   <= 1'b0;
    end
  end

  assign wave_out = wave;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) begin
        case (bus_addr)
          ADR_CTRL: bus_rdata <= {{(W-CTRL_BITS){1'b0}}, ext_q, run_q, mode_q};
          ADR_CNT:  bus_rdata <= cnt;
          ADR_CMP:  bus_rdata <= ocr_buf;
          default:  bus_rdata <= {{(W-2){1'b0}}, ovf_irq, match_irq};
        endcase
      end
    end
  end

  assert_match_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (match_irq && !(flag_wr && bus_wdata[0])) |=> match_irq);

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf_irq && !(flag_wr && bus_wdata[1])) |=> ovf_irq);
endmodule

// File: tb/sim_tmr8_unit.sv
module sim_tmr8_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       presc_tick = 1'b0, ext_tick = 1'b0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, wave_out, match_irq, ovf_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  tmr8_unit u0 (
    .clk(clk), .rst(rst), .presc_tick(presc_tick), .ext_tick(ext_tick),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .wave_out(wave_out),
    .match_irq(match_irq), .ovf_irq(ovf_irq)
  );

  task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read data returns
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check_val(bus_rdata, 8'hxx, "unexpected read");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_val(bus_rdata, e, t);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic ticks(input int n, input bit use_ext);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      presc_tick = !use_ext;
      ext_tick   = use_ext;
    end
    @(negedge clk);
    presc_tick = 1'b0;
    ext_tick   = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    rd_expect(2'd0, 8'h00, "R1 ctrl");
    rd_expect(2'd1, 8'h00, "R1 count");
    rd_expect(2'd2, 8'h00, "R1 cmp");
    rd_expect(2'd3, 8'h00, "R1 flags");
    check_val({7'd0, wave_out}, 8'h00, "R1 wave");
    // R2 stopped
    ticks(5, 1'b0);
    rd_expect(2'd1, 8'h00, "R2 hold");
    // R5 / R11 free-running match
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h03);
    ticks(3, 1'b0);
    rd_expect(2'd1, 8'h03, "R4 count up");
    rd_expect(2'd3, 8'h00, "R5 no match yet");
    ticks(1, 1'b0);
    rd_expect(2'd3, 8'h01, "R5 match flag");
    check_val({7'd0, wave_out}, 8'h01, "R11 toggle");
    // R3 source select
    wr(2'd0, 8'h0C);
    ticks(3, 1'b0);
    rd_expect(2'd1, 8'h04, "R3 presc ignored");
    ticks(2, 1'b1);
    rd_expect(2'd1, 8'h06, "R3 ext ticks");
    wr(2'd0, 8'h04);
    wr(2'd3, 8'h01);
    rd_expect(2'd3, 8'h00, "R5 clear");
    // R4 overflow
    wr(2'd1, 8'hFE);
    ticks(2, 1'b0);
    rd_expect(2'd1, 8'h00, "R4 wrap");
    rd_expect(2'd3, 8'h02, "R4 ovf flag");
    check_val({7'd0, ovf_irq}, 8'h01, "R4 ovf_irq");
    wr(2'd3, 8'h02);
    // R9 write suppresses match
    wr(2'd1, 8'h03);
    ticks(1, 1'b0);
    rd_expect(2'd3, 8'h00, "R9 blocked");
    check_val({7'd0, wave_out}, 8'h01, "R9 wave kept");
    wr(2'd1, 8'h02);
    ticks(2, 1'b0);
    rd_expect(2'd3, 8'h01, "R9 later match");
    check_val({7'd0, wave_out}, 8'h00, "R11 toggle back");
    wr(2'd3, 8'h03);
    // R6 clear-on-match
    wr(2'd0, 8'h06);
    wr(2'd2, 8'h05);
    wr(2'd1, 8'h00);
    ticks(6, 1'b0);
    rd_expect(2'd1, 8'h00, "R6 cleared");
    rd_expect(2'd3, 8'h01, "R6 match only");
    check_val({7'd0, wave_out}, 8'h01, "R11 ctc toggle");
    wr(2'd3, 8'h03);
    // R7 / R8 fast PWM
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h20);
    rd_expect(2'd2, 8'h20, "R7 buffer read");
    ticks(18, 1'b0);
    rd_expect(2'd1, 8'h22, "R7 count");
    rd_expect(2'd3, 8'h00, "R7 write deferred");
    wr(2'd1, 8'hFE);
    ticks(2, 1'b0);
    rd_expect(2'd3, 8'h02, "R8 roll ovf");
    check_val({7'd0, wave_out}, 8'h01, "R8 set at roll");
    ticks(32, 1'b0);
    rd_expect(2'd3, 8'h02, "R7 before match");
    ticks(1, 1'b0);
    rd_expect(2'd3, 8'h03, "R7 loaded match");
    check_val({7'd0, wave_out}, 8'h00, "R8 clear at match");
    wr(2'd3, 8'h01);
    rd_expect(2'd3, 8'h02, "R5 per-bit clear");
    wr(2'd3, 8'h02);
    // R10 phase-correct
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h10);
    wr(2'd1, 8'hFD);
    ticks(3, 1'b0);
    rd_expect(2'd1, 8'hFE, "R10 turn");
    ticks(238, 1'b0);
    rd_expect(2'd1, 8'h10, "R10 descend");
    rd_expect(2'd3, 8'h00, "R10 no flags");
    ticks(1, 1'b0);
    check_val({7'd0, wave_out}, 8'h01, "R10 set falling");
    ticks(15, 1'b0);
    rd_expect(2'd1, 8'h00, "R10 bottom");
    rd_expect(2'd3, 8'h03, "R10 ovf bottom");
    ticks(17, 1'b0);
    rd_expect(2'd1, 8'h11, "R10 rising");
    check_val({7'd0, wave_out}, 8'h00, "R10 clear rising");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check_val(8'(exp_q.size()), 8'h00, "scoreboard drained");
    finish_run();
  end
endmodule